// File: doc/BRIEF.md
# Two-Way Set-Associative Lookup and Replacement Unit

This block holds the tag, valid and data storage of a small two-way set-associative cache whose blocks are one word wide. A request presents a byte address; the word index bits just above the two-bit byte offset choose a set, and the tag bits above the index are compared against both ways of that set at once. The hit and the selected word come out in the same cycle as the request. A 2-to-1 way multiplexer, steered by the hit decision, picks the word.

On a miss the unit changes nothing. It reports which way a refill of that set would take. The requester fetches the word from the next level and returns it on the fill port. The fill writes tag, data and valid into the chosen way. Victim choice works in this order: a way that already holds the address, then an invalid way, then the least recently used way. A single recency bit per set records this. Every hit and every fill updates the bit, so two addresses that collide in one set can both stay resident.

Top module: `cache2w_lookup`

## Requirements
- R1: Address bits [1:0] are a byte offset and do not affect the lookup. Bits [IDX_W+1:2] select the set (word address modulo SETS). The remaining upper TAG_W bits form the tag.
- R2: `hit` is high when `req_valid` is high and a valid way of the selected set holds the request tag. `miss` is high when `req_valid` is high and no such way exists. Both are low when `req_valid` is low. `rdata` is the word of the matching way, or 0 when there is no hit.
- R3: A read or write request that misses changes no stored tag, data, valid or recency state.
- R4: A write request that hits replaces the data word of the matching way. Its tag and valid bit are left unchanged.
- R5: A fill writes the fill tag and word into the chosen way and sets its valid bit. A later request for that address hits and returns the filled word.
- R6: The fill way is chosen in this order: the way that already holds a valid copy of the fill address; otherwise an invalid way (way 0 when both ways are invalid); otherwise the least recently used way.
- R7: Each hit and each fill marks the referenced way of its set as most recently used. `victim_way` (0 means way 0, 1 means way 1) shows the way that a fill to the set of `req_addr` would take. It follows the R6 order, assuming the address is not resident.
- R8: When `fill_valid` and a write request occur in the same cycle, the fill is performed and the write request causes no update.
- R9: Reset, synchronous with `rst_n` low, clears all valid bits and all recency bits to 0.
- R10: Start from reset with SETS=2. Replay the word references 0,4,0,4,0,4,0,4 (byte addresses 0 and 16), refilling after each miss. The result is exactly two misses, followed by hits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | Request is a write (1) or read (0) |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write word |
| fill_valid | input | 1 | Refill word present |
| fill_addr | input | ADDR_W | Refill byte address |
| fill_data | input | DATA_W | Refill word |
| hit | output | 1 | Request found in a way |
| miss | output | 1 | Request not found |
| rdata | output | DATA_W | Word from the matching way, 0 on no hit |
| victim_way | output | 1 | Way a fill to the request's set would use |

## Verification
The alternating two-address reference string is the core test. A direct-mapped scheme would miss on all eight references. This unit settles after two misses, which shows that the two ways coexist and that recency is updated on hits.

A third address mapping to the same set shows that the least recently used way is evicted and that the most recent way survives. Offset-only address changes show that the byte offset is ignored. Write misses, then write hits, then a write colliding with a fill show that each one leaves or changes state as required. A repeated fill of a resident address is also tried. Its effect on the reported victim shows whether the unit reuses the existing way or allocates a duplicate copy.

// File: rtl/cache2w_pkg.sv
// Shared helpers for the two-way lookup unit.
// Assumes exactly two ways; a way number is one bit.
package cache2w_pkg;

    // Victim order among non-resident candidates: invalid way first
    // (way 0 if both invalid), else the least recently used way.
    function automatic logic pick_victim(input logic vld0, input logic vld1,
                                         input logic lru_way);
        if (!vld0)      return 1'b0;
        else if (!vld1) return 1'b1;
        else            return lru_way;
    endfunction

endpackage

// File: rtl/cache2w_way.sv
// One way of the cache: tag, data and valid storage for every set.
// Read ports are combinational; one write port updates on the clock.
// Assumes SETS >= 2 and a single writer per cycle.
module cache2w_way #(
    parameter int SETS   = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [TAG_W-1:0]  fl_tag,
    output logic              fl_hit,
    output logic              fl_vld,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic [SETS-1:0]   vld_q;

    // Valid bits: cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en && wr_fill)
            vld_q[wr_idx] <= 1'b1;
    end

    // Tag and data storage: data on any write, tag only on a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            dat_q[wr_idx] <= wr_data;
            if (wr_fill)
                tag_q[wr_idx] <= wr_tag;
        end
    end

    // Lookup port comparison and word read.
    always_comb begin
        rd_vld  = vld_q[rd_idx];
        rd_hit  = rd_vld && (tag_q[rd_idx] == rd_tag);
        rd_data = dat_q[rd_idx];
    end

    // Fill port residency check.
    always_comb begin
        fl_vld = vld_q[fl_idx];
        fl_hit = fl_vld && (tag_q[fl_idx] == fl_tag);
    end

    // R5: after a fill the written set is valid and carries the fill tag.
    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fill) |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/cache2w_lru.sv
// Per-set recency bit. The bit holds the least recently used way.
// A touch marks the touched way as most recent. Two read ports.
module cache2w_lru #(
    parameter int SETS   = 2,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic [IDX_W-1:0] qa_idx,
    output logic             qa_lru,
    input  logic [IDX_W-1:0] qb_idx,
    output logic             qb_lru
);
    logic [SETS-1:0] lru_q;

    // Recency update: the other way becomes the replacement candidate.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lru_q <= '0;
        else if (touch_en)
            lru_q[touch_idx] <= ~touch_way;
    end

    // Combinational recency reads.
    always_comb begin
        qa_lru = lru_q[qa_idx];
        qb_lru = lru_q[qb_idx];
    end

    // R7: a referenced way is never the candidate right after the reference.
    a_r7_touch_marks_mru: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way)));

endmodule

// File: rtl/cache2w_lookup.sv
// Two-way set-associative lookup and replacement unit, one-word blocks.
// A request is answered combinationally. Fills and write hits update on the clock.
// A fill has priority over a same-cycle request for state updates.
// Assumes SETS is a power of two, at least 2.
module cache2w_lookup #(
    parameter int SETS    = 2,
    parameter int TAG_W   = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = 2,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic              miss,
    output logic [DATA_W-1:0] rdata,
    output logic              victim_way
);
    import cache2w_pkg::*;

    localparam int NWAYS = 2;

    logic [IDX_W-1:0]  req_idx, fill_idx, wr_idx;
    logic [TAG_W-1:0]  req_tag, fill_tag;
    logic [NWAYS-1:0]  rd_hit, rd_vld, fl_hit, fl_vld, wr_en;
    logic [DATA_W-1:0] rd_data [NWAYS];
    logic [DATA_W-1:0] wr_data;
    logic              fill_way, lru_req, lru_fill;
    logic              touch_en, touch_way;
    logic [IDX_W-1:0]  touch_idx;

    // Address split into set index and tag (byte offset dropped).
    always_comb begin
        req_idx  = req_addr[OFF_W +: IDX_W];
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        fill_idx = fill_addr[OFF_W +: IDX_W];
        fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    end

    // Shared write port: the fill wins, else a write hit.
    always_comb begin
        wr_idx  = fill_valid ? fill_idx  : req_idx;
        wr_data = fill_valid ? fill_data : req_wdata;
    end

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        // Per-way write enable from the fill choice or the write hit.
        assign wr_en[w] = fill_valid ? (fill_way == (w == 1))
                                     : (req_valid && req_write && rd_hit[w]);

        cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) way_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (req_idx),
            .rd_tag  (req_tag),
            .rd_hit  (rd_hit[w]),
            .rd_vld  (rd_vld[w]),
            .rd_data (rd_data[w]),
            .fl_idx  (fill_idx),
            .fl_tag  (fill_tag),
            .fl_hit  (fl_hit[w]),
            .fl_vld  (fl_vld[w]),
            .wr_en   (wr_en[w]),
            .wr_fill (fill_valid),
            .wr_idx  (wr_idx),
            .wr_tag  (fill_tag),
            .wr_data (wr_data)
        );
    end

    // Fill way: resident copy, else invalid way, else LRU way.
    always_comb begin
        if (fl_hit[1])      fill_way = 1'b1;
        else if (fl_hit[0]) fill_way = 1'b0;
        else                fill_way = pick_victim(fl_vld[0], fl_vld[1], lru_fill);
    end

    // Recency reference: a fill, else a request hit.
    always_comb begin
        touch_en  = fill_valid || (req_valid && (|rd_hit));
        touch_idx = fill_valid ? fill_idx : req_idx;
        touch_way = fill_valid ? fill_way : rd_hit[1];
    end

    cache2w_lru #(.SETS(SETS)) lru_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .touch_way (touch_way),
        .qa_idx    (req_idx),
        .qa_lru    (lru_req),
        .qb_idx    (fill_idx),
        .qb_lru    (lru_fill)
    );

    // Hit decision, then way multiplexer on the data.
    always_comb begin
        hit        = req_valid && (|rd_hit);
        miss       = req_valid && !(|rd_hit);
        rdata      = !hit ? '0 : (rd_hit[1] ? rd_data[1] : rd_data[0]);
        victim_way = pick_victim(rd_vld[0], rd_vld[1], lru_req);
    end

    // R2: the two ways never both hold the requested address.
    a_r2_no_double_match: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit[0] && rd_hit[1]));

    // R2: a hit only accompanies a request and never a miss.
    a_r2_hit_excludes_miss: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_valid && !miss));

    // R6: with one way free and no resident copy, the fill uses the free way.
    a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fl_hit == 2'b00 && fl_vld != 2'b11) |-> !fl_vld[fill_way]);

endmodule

// File: tb/cache2w_lookup_tb_top.sv
`timescale 1ns/1ps
module cache2w_lookup_tb_top;
    localparam int SETS   = 2;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = TAG_W + $clog2(SETS) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, fill_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0, fill_data = '0;
    logic hit, miss, victim_way;
    logic [DATA_W-1:0] rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic s_hit, s_miss, s_vic;
    logic [DATA_W-1:0] s_rdata;

    always #2.5 clk = ~clk;

    cache2w_lookup #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_data(fill_data), .hit(hit), .miss(miss),
        .rdata(rdata), .victim_way(victim_way)
    );

    function automatic logic [DATA_W-1:0] wval(input int word);
        return 32'hA000_0000 + DATA_W'(word);
    endfunction

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request for one cycle; capture outputs before the edge.
    task automatic do_req(input logic we, input int addr, input logic [DATA_W-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = ADDR_W'(addr); req_wdata = wd;
        fill_valid = 1'b0;
        #1;
        s_hit = hit; s_miss = miss; s_rdata = rdata; s_vic = victim_way;
    endtask

    task automatic do_fill(input int addr, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        fill_valid = 1'b1; fill_addr = ADDR_W'(addr); fill_data = d;
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; fill_valid = 1'b0;
        #1;
        s_hit = hit; s_miss = miss;
    endtask

    task automatic t_reset();
        go_idle();
        check(!s_hit && !s_miss, "R2 idle outputs low", {30'b0, s_hit, s_miss}, '0);
        do_req(1'b0, 0, '0);
        check(s_miss && !s_hit, "R9 empty after reset", {31'b0, s_hit}, '0);
        check(s_rdata == '0, "R2 rdata zero on miss", s_rdata, '0);
        check(s_vic == 1'b0, "R9 victim way0 when empty", {31'b0, s_vic}, '0);
    endtask

    task automatic t_refstring();
        int misses = 0;
        for (int i = 0; i < 8; i++) begin
            int word = (i % 2 == 1) ? 4 : 0;
            do_req(1'b0, word * 4, '0);
            if (s_miss) begin
                misses++;
                do_fill(word * 4, wval(word));
            end else begin
                check(s_rdata == wval(word), "R10 hit data", s_rdata, wval(word));
            end
        end
        check(misses == 2, "R10 miss count", DATA_W'(misses), 32'd2);
    endtask

    task automatic t_offset();
        do_req(1'b0, 16 + 3, '0);
        check(s_hit && s_rdata == wval(4), "R1 offset ignored", s_rdata, wval(4));
    endtask

    task automatic t_conflict();
        do_req(1'b0, 32, '0);
        check(s_miss, "R2 third address misses", {31'b0, s_miss}, 32'd1);
        check(s_vic == 1'b0, "R7 victim is LRU way0", {31'b0, s_vic}, '0);
        do_fill(32, wval(8));
        do_req(1'b0, 16, '0);
        check(s_hit && s_rdata == wval(4), "R6 MRU way kept", s_rdata, wval(4));
        do_req(1'b0, 0, '0);
        check(s_miss, "R6 LRU way evicted", {31'b0, s_miss}, 32'd1);
        do_req(1'b0, 32, '0);
        check(s_hit && s_rdata == wval(8), "R5 filled word hits", s_rdata, wval(8));
    endtask

    task automatic t_write_miss();
        do_req(1'b0, 16, '0);
        do_req(1'b1, 48, 32'hDEAD_BEEF);
        check(s_miss, "R3 write miss reported", {31'b0, s_miss}, 32'd1);
        do_req(1'b0, 48, '0);
        check(s_miss, "R3 no allocate on write miss", {31'b0, s_miss}, 32'd1);
        check(s_vic == 1'b0, "R3 recency unchanged by miss", {31'b0, s_vic}, '0);
        do_req(1'b0, 32, '0);
        check(s_hit && s_rdata == wval(8), "R3 way0 intact", s_rdata, wval(8));
        do_req(1'b0, 16, '0);
        check(s_hit && s_rdata == wval(4), "R3 way1 intact", s_rdata, wval(4));
    endtask

    task automatic t_write_hit();
        do_req(1'b1, 16, 32'h1234_5678);
        check(s_hit, "R4 write hit reported", {31'b0, s_hit}, 32'd1);
        do_req(1'b0, 16, '0);
        check(s_hit && s_rdata == 32'h1234_5678, "R4 write hit data", s_rdata, 32'h1234_5678);
    endtask

    task automatic t_fill_priority();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(16); req_wdata = 32'hFFFF_0000;
        fill_valid = 1'b1; fill_addr = ADDR_W'(4); fill_data = wval(1);
        do_req(1'b0, 16, '0);
        check(s_hit && s_rdata == 32'h1234_5678, "R8 write dropped under fill", s_rdata, 32'h1234_5678);
        do_req(1'b0, 4, '0);
        check(s_hit && s_rdata == wval(1), "R8 fill performed", s_rdata, wval(1));
    endtask

    task automatic t_dup_fill();
        do_fill(4, 32'hB000_0001);
        do_req(1'b0, 4, '0);
        check(s_hit && s_rdata == 32'hB000_0001, "R6 refill updates data", s_rdata, 32'hB000_0001);
        check(s_vic == 1'b1, "R6 resident refill reuses its way", {31'b0, s_vic}, 32'd1);
        do_fill(20, wval(5));
        do_req(1'b0, 20, '0);
        check(s_hit && s_rdata == wval(5), "R5 second way filled", s_rdata, wval(5));
        do_req(1'b0, 4, '0);
        check(s_hit && s_rdata == 32'hB000_0001, "R6 both ways resident", s_rdata, 32'hB000_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_refstring();
        t_offset();
        t_conflict();
        t_write_miss();
        t_write_hit();
        t_fill_priority();
        t_dup_fill();
        go_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule